// File: doc/BRIEF.md
# Muxed-D Scan Chain Wrapper for a Register–Adder–Register Datapath

This block is a small datapath made testable by scan. Two operand registers capture input words on the falling clock edge. An adder combines them, and a result register stores the sum on the rising clock edge. A functional capture enable gates the result register's clock. A level-sensitive hold latch presents the result on the output. Every flip-flop is a multiplexed-D scan cell. All cells are stitched into one serial chain that runs from a scan input pin to a scan output pin.

For test, a test-mode pin takes control away from internal logic. When it is high:
- every cell's asynchronous reset comes from a dedicated test-reset pin instead of the internal reset synchroniser;
- the clock gate is forced open;
- the output latch becomes transparent.

Falling-edge cells sit at the head of the chain, ahead of all rising-edge cells, so that each clock period moves data exactly one position. With test mode low, the override pins have no effect, and the block behaves as the same registers without scan.

Top module: `scan_wrap_dp`

## Requirements
- R1: With scan enable high, every cell loads its chain predecessor on its own active edge, and the first cell loads `scan_in`. The chain advances one position per clock period.
- R2: `scan_out` is the last cell's output. It changes only at a rising clock edge and is steady across the falling edge.
- R3: Chain order, from head to tail:
  - operand A bits 0..W-1 (falling edge);
  - operand B bits 0..W-1 (falling edge);
  - result bits 0..W-1 (rising edge).
  All falling-edge cells therefore come before all rising-edge cells.
- R4: With scan enable low, each operand cell captures its input on the falling edge. Each result cell captures (A + B) mod 2^W on the rising edge when its clock is enabled.
- R5: With test mode high, every cell's asynchronous reset follows `test_rst_n` (low clears to 0), and `rst_n` is ignored.
- R6: With test mode high, the result clock gate is open whatever `cap_en` is.
- R7: With test mode high, `y_o` follows the result register whatever `hold_i` is.
- R8: With test mode low, `test_rst_n` has no effect. A low `rst_n` clears every cell at once, and the clear is released on the second rising edge after `rst_n` goes high.
- R9: With test mode low, `cap_en` low keeps the result register unchanged. `hold_i` high freezes `y_o`, and `hold_i` low makes `y_o` follow the result register.
- R10: The chain length is 3·W, with W ≥ 2 (an elaboration check). A bit entering at `scan_in` appears at `scan_out` after exactly 3·W clock periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port-level clock for all cells |
| rst_n | input | 1 | Functional asynchronous reset, active low |
| test_mode | input | 1 | Test-mode override enable |
| test_rst_n | input | 1 | Cell reset used in test mode, active low |
| scan_en | input | 1 | Selects shift (1) or capture (0) |
| scan_in | input | 1 | Serial input to the head of the chain |
| cap_en | input | 1 | Functional clock enable of the result register |
| hold_i | input | 1 | Freezes the output latch when high (functional mode) |
| a_i | input | W | Operand A input word |
| b_i | input | W | Operand B input word |
| y_o | output | W | Latched result word |
| scan_out | output | 1 | Serial output from the tail of the chain |

## Verification
The embedded properties check the following on every relevant edge:
- each cell's choice between predecessor and functional input;
- the one-step move of the chain tail into `scan_out`;
- the forced-open clock gate and the transparent latch in test mode;
- the reset overrides.

Only the bench's scenarios can show the whole-chain behaviour. This covers the exact head-to-tail bit order across the mixed-edge boundary, a full load–capture–unload pattern, the two-edge reset release, and the fact that `test_rst_n` and `hold_i` changes leave nothing disturbed when they must.

// File: rtl/scanwrap_pkg.sv
package scanwrap_pkg;

   typedef enum logic {
      EDGE_POS = 1'b0,
      EDGE_NEG = 1'b1
   } edge_e;

   // three banks of W cells: operand A, operand B, result
   localparam int unsigned BANKS = 3;

   function automatic int unsigned chain_len(input int unsigned w);
      return BANKS * w;
   endfunction

endpackage

// File: rtl/scan_cell.sv
module scan_cell
   import scanwrap_pkg::*;
#(
   parameter edge_e EDGE    = EDGE_POS,
   parameter logic  RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic arst_n,
   input  logic se,
   input  logic si,
   input  logic d,
   output logic q
);

   logic nxt;
   assign nxt = se ? si : d;

   generate
      if (EDGE == EDGE_NEG) begin : g_neg
         always_ff @(negedge clk or negedge arst_n) begin
            if (!arst_n) q <= RST_VAL;
            else         q <= nxt;
         end

         // R1
         neg_shift_chk: assert property (@(negedge clk) disable iff (!arst_n)
            se |=> (q == $past(si)));
         // R4
         neg_capture_chk: assert property (@(negedge clk) disable iff (!arst_n)
            !se |=> (q == $past(d)));
      end else begin : g_pos
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) q <= RST_VAL;
            else         q <= nxt;
         end

         // R1
         pos_shift_chk: assert property (@(posedge clk) disable iff (!arst_n)
            se |=> (q == $past(si)));
         // R4
         pos_capture_chk: assert property (@(posedge clk) disable iff (!arst_n)
            !se |=> (q == $past(d)));
      end
   endgenerate

endmodule

// File: rtl/scan_bank.sv
module scan_bank
   import scanwrap_pkg::*;
#(
   parameter int unsigned W    = 8,
   parameter edge_e       EDGE = EDGE_POS
) (
   input  logic         clk,
   input  logic         arst_n,
   input  logic         se,
   input  logic         si,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic         so
);

   generate
      if (W < 1) begin : g_bad_w
         $error("scan_bank: W must be at least 1");
      end

      for (genvar i = 0; i < W; i++) begin : g_cell
         logic link;
         if (i == 0) begin : g_head
            assign link = si;
         end else begin : g_body
            assign link = q[i-1];
         end

         scan_cell #(
            .EDGE   (EDGE),
            .RST_VAL(1'b0)
         ) u_cell (
            .clk   (clk),
            .arst_n(arst_n),
            .se    (se),
            .si    (link),
            .d     (d[i]),
            .q     (q[i])
         );
      end
   endgenerate

   assign so = q[W-1];

endmodule

// File: rtl/clk_gate.sv
module clk_gate (
   input  logic clk,
   input  logic en,
   input  logic force_on,
   output logic gclk
);

   logic en_lat;

   // enable captured while the clock is low, so gclk never glitches
   always_latch begin
      if (!clk) en_lat = en | force_on;
   end

   assign gclk = clk & en_lat;

   // R6
   gate_open_chk: assert property (@(posedge clk) disable iff (!force_on)
      $past(force_on) |-> en_lat);

endmodule

// File: rtl/hold_latch.sv
module hold_latch #(
   parameter int unsigned W = 8
) (
   input  logic         hold,
   input  logic         force_open,
   input  logic         sample_clk,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic open_w;
   assign open_w = !hold || force_open;

   always_latch begin
      if (open_w) q = d;
   end

   // R7
   latch_open_chk: assert property (@(negedge sample_clk) disable iff (!force_open)
      force_open |-> (q == d));

endmodule

// File: rtl/rst_sync.sv
module rst_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic srst_n
);

   logic [STAGES-1:0] pipe;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rst_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) pipe <= '0;
      else         pipe <= {pipe[STAGES-2:0], 1'b1};
   end

   assign srst_n = pipe[STAGES-1];

endmodule

// File: rtl/scan_wrap_dp.sv
module scan_wrap_dp
   import scanwrap_pkg::*;
#(
   parameter int unsigned W          = 8,
   parameter int unsigned SYNC_DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         test_mode,
   input  logic         test_rst_n,
   input  logic         scan_en,
   input  logic         scan_in,
   input  logic         cap_en,
   input  logic         hold_i,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] y_o,
   output logic         scan_out
);

   localparam int unsigned CHAIN_LEN = chain_len(W);

   generate
      if (W < 2) begin : g_bad_w
         $error("scan_wrap_dp: W must be at least 2");
      end
      if (CHAIN_LEN != 3 * W) begin : g_bad_len
         $error("scan_wrap_dp: chain length mismatch");
      end
   endgenerate

   logic         int_rst_n;
   logic         cell_rst_n;
   logic         res_clk;
   logic [W-1:0] a_q, b_q, r_q, sum_w;
   logic         a_so, b_so, r_so;

   rst_sync #(.STAGES(SYNC_DEPTH)) u_rsync (
      .clk   (clk),
      .arst_n(rst_n),
      .srst_n(int_rst_n)
   );

   // port-level reset takes over in test mode
   assign cell_rst_n = test_mode ? test_rst_n : int_rst_n;

   clk_gate u_cg (
      .clk     (clk),
      .en      (cap_en),
      .force_on(test_mode),
      .gclk    (res_clk)
   );

   // falling-edge banks lead the chain
   scan_bank #(.W(W), .EDGE(EDGE_NEG)) u_bank_a (
      .clk(clk), .arst_n(cell_rst_n), .se(scan_en), .si(scan_in),
      .d(a_i), .q(a_q), .so(a_so)
   );

   scan_bank #(.W(W), .EDGE(EDGE_NEG)) u_bank_b (
      .clk(clk), .arst_n(cell_rst_n), .se(scan_en), .si(a_so),
      .d(b_i), .q(b_q), .so(b_so)
   );

   assign sum_w = a_q + b_q;

   scan_bank #(.W(W), .EDGE(EDGE_POS)) u_bank_r (
      .clk(res_clk), .arst_n(cell_rst_n), .se(scan_en), .si(b_so),
      .d(sum_w), .q(r_q), .so(r_so)
   );

   assign scan_out = r_so;

   hold_latch #(.W(W)) u_hold (
      .hold      (hold_i),
      .force_open(test_mode),
      .sample_clk(clk),
      .d         (r_q),
      .q         (y_o)
   );

   // R2
   tail_step_chk: assert property (@(posedge clk) disable iff (!cell_rst_n)
      $past(test_mode && scan_en && cell_rst_n) |-> (scan_out == $past(r_q[W-2])));
   // R5
   test_rst_chk: assert property (@(posedge clk)
      (test_mode && !test_rst_n) |-> (scan_out == 1'b0));
   // R8
   func_rst_chk: assert property (@(posedge clk)
      (!test_mode && !rst_n) |-> (scan_out == 1'b0));

endmodule

// File: tb/scan_wrap_dp_tb.sv
`timescale 1ns/1ps
module scan_wrap_dp_tb;

   localparam int W = 8;
   localparam int N = 3 * W;

   logic         clk = 1'b0;
   logic         rst_n, test_mode, test_rst_n, scan_en, scan_in, cap_en, hold_i;
   logic [W-1:0] a_i, b_i, y_o;
   logic         scan_out;

   always #2.5 clk = ~clk;

   scan_wrap_dp #(.W(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .test_rst_n(test_rst_n),
      .scan_en(scan_en), .scan_in(scan_in), .cap_en(cap_en), .hold_i(hold_i),
      .a_i(a_i), .b_i(b_i), .y_o(y_o), .scan_out(scan_out)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;

   // reference state
   logic [W-1:0] ma, mb, mr, my;
   int           sync_cnt;

   function automatic logic [W-1:0] ref_sum(input logic [W-1:0] x, input logic [W-1:0] y);
      return x + y;
   endfunction

   task automatic cmp(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // apply current inputs for one clock period: rising edge, then falling edge
   task automatic step(input string tag);
      logic          rst_now, pos_ok, neg_ok;
      logic [W-1:0]  na, nb;
      rst_now = test_mode ? !test_rst_n : (sync_cnt < 2);
      if (!rst_n) sync_cnt = 0;
      if (test_mode ? !test_rst_n : !rst_n) begin
         ma = '0; mb = '0; mr = '0;
      end
      if (!hold_i || test_mode) my = mr;
      #0.5;
      cmp({tag, " R7/R9 y pre"}, y_o, my);
      @(posedge clk); #1;
      pos_ok = test_mode ? test_rst_n : (rst_n && sync_cnt >= 2);
      if (rst_n && sync_cnt < 2) sync_cnt++;
      if (pos_ok && (test_mode || cap_en))
         mr = scan_en ? {mr[W-2:0], mb[W-1]} : ref_sum(ma, mb);
      if (!hold_i || test_mode) my = mr;
      cmp({tag, " R2 scan_out after rise"}, W'(scan_out), W'(mr[W-1]));
      cmp({tag, " y after rise"}, y_o, my);
      @(negedge clk); #1;
      neg_ok = test_mode ? test_rst_n : (rst_n && sync_cnt >= 2);
      if (neg_ok) begin
         na = scan_en ? {ma[W-2:0], scan_in}  : a_i;
         nb = scan_en ? {mb[W-2:0], ma[W-1]}  : b_i;
         ma = na; mb = nb;
      end
      cmp({tag, " R2 scan_out steady at fall"}, W'(scan_out), W'(mr[W-1]));
      if (rst_now) cmp({tag, " R5/R8 cleared"}, W'(scan_out), '0);
   endtask

   task automatic func_rand(input string tag, input int n, input bit poke_trst);
      for (int i = 0; i < n; i++) begin
         scan_en = 0;
         a_i = W'($urandom); b_i = W'($urandom);
         cap_en = ($urandom % 3) != 0;
         hold_i = ($urandom % 4) == 0;
         if (poke_trst) test_rst_n = $urandom % 2;
         step(tag);
      end
      test_rst_n = 1;
   endtask

   task automatic scan_pattern(input string tag);
      test_mode = 1; hold_i = 1; cap_en = 0;
      for (int i = 0; i < N; i++) begin
         scan_en = 1; scan_in = $urandom % 2;
         step({tag, " load R1 R6 R7"});
      end
      scan_en = 0; a_i = W'($urandom); b_i = W'($urandom);
      step({tag, " capture R4 R6"});
      for (int i = 0; i < N; i++) begin
         scan_en = 1; scan_in = $urandom % 2;
         step({tag, " unload R3 R10"});
      end
   endtask

   initial begin
      #200000;
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5CA1_0001));
      rst_n = 0; test_mode = 0; test_rst_n = 1; scan_en = 0; scan_in = 0;
      cap_en = 0; hold_i = 0; a_i = '0; b_i = '0;
      ma = '0; mb = '0; mr = '0; my = '0; sync_cnt = 0;

      // reset state R8
      step("R8 reset");
      step("R8 reset");
      rst_n = 1;
      a_i = 8'h11; b_i = 8'h22; cap_en = 1;
      step("R8 release1");
      step("R8 release2");
      step("R4 first capture");

      // directed wrap of the adder R4
      a_i = 8'hFF; b_i = 8'h02; step("R4 wrap a");
      step("R4 wrap b");
      cmp("R4 wrap sum", y_o, 8'h01);

      // functional random with test_rst_n toggling: R8 R9
      func_rand("R9 func", 60, 1'b1);

      // test pattern R1..R7, R10
      scan_pattern("pat1");

      // directed: walking one through the whole chain R10 R3
      scan_en = 1; scan_in = 1; step("R10 inject");
      scan_in = 0;
      for (int i = 1; i < N; i++) step("R10 walk");
      cmp("R10 one at tail", W'(scan_out), W'(1));

      // rst_n ignored in test mode R5
      rst_n = 0;
      for (int i = 0; i < 6; i++) begin scan_in = $urandom % 2; step("R5 rst_n ignored"); end
      rst_n = 1;
      for (int i = 0; i < 3; i++) step("R5 sync recover");

      // test reset clears R5
      test_rst_n = 0; scan_in = 1; step("R5 trst clear");
      test_rst_n = 1;
      scan_pattern("pat2");

      // back to functional
      test_mode = 0; hold_i = 0;
      func_rand("R9 func2", 40, 1'b0);

      // hold freezes, cap_en low keeps R9
      cap_en = 0; hold_i = 1; a_i = 8'h5A; b_i = 8'h33;
      step("R9 hold"); step("R9 hold");
      hold_i = 0; step("R9 release hold");

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule